// File: doc/BRIEF.md
# Time-synchronized pin waveform generator

The block keeps a time-of-day counter (seconds plus nanoseconds) and drives a set of timing output pins from it. Each pin has its own low duration, high duration and a configuration word that selects idle or clock action and an optional seconds-locked mode. In free-running clock action a pin toggles between a high phase and a low phase of the programmed lengths. The waveform starts at the moment the configuration is written, because the block cannot be given an absolute start time.

In seconds-locked mode the pin emits one pulse per second. The low-duration register becomes the delay after the seconds increment and the high-duration register becomes the pulse width. With the default one-second wrap this is a 1-PPS output whose phase is set by the delay. A single synchronous write port, with a pin index and a register select, configures every pin.

Top module: `tod_pin_wavegen`

## Requirements
- R1: During and after reset every pin output is low, the nanosecond count is 0, the seconds count is 0 and every pin is idle. Each pin's low and high registers hold 1000.
- R2: The nanosecond count rises by NS_STEP every clock. When it would reach NS_WRAP it wraps to (count + NS_STEP - NS_WRAP), and in that same cycle the seconds count rises by one.
- R3: A write uses wr_addr[3:2] as the pin index and wr_addr[1:0] as the register: 0 low duration, 1 high duration, 2 configuration, 3 no register (ignored). In the configuration, bit 0 is the action (0 idle, 1 clock) and bit 1 is the seconds-locked option. An idle pin drives low.
- R4: Writing a configuration with action clock and no seconds-locked option starts the pin high in the clock edge of the write. It stays high for ceil(high/NS_STEP) cycles and low for ceil(low/NS_STEP) cycles, and repeats.
- R5: Each pin starts at its own configuration write, so pins started one cycle apart stay one cycle apart. A write to one pin does not disturb another.
- R6: A duration write is accepted only if 6 < value <= 0x3FFFFFFF. Otherwise the previous value stays in place.
- R7: A duration written while a pin runs takes effect at that pin's next phase change. The phase in progress keeps its length.
- R8: Writing a configuration with action idle drives the pin low in the next cycle. The durations are kept, so a later clock write resumes with them.
- R9: In seconds-locked clock action the pin stays low until the first seconds increment after the configuration write. From then on it is high exactly while delay <= nanosecond count < delay + width, using the durations captured at the latest seconds increment.
- R10: A seconds-locked pulse whose delay plus width passes NS_WRAP is cut off at the seconds increment. The next delay then starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Pin index [3:2], register select [1:0] |
| wr_data | input | 32 | Write data |
| pin_out | output | 4 | Timing output pins |
| tod_sec | output | 32 | Seconds count |
| tod_ns | output | 30 | Nanosecond count |

## Verification
Free-running pins are driven from a table of low/high pairs that includes the smallest legal value, values that are not multiples of the step, and unequal and equal phases. Run lengths are measured after each start, which tells rounding errors apart from phase swaps. Directed sequences separate a mid-phase duration update from an immediate one, a rejected write from an accepted one, and two staggered starts from aligned ones. Seconds-locked pulses are compared cycle by cycle against a window computed from the observed time of day, once with the window inside the second and once with it crossing the wrap. This exposes late arming, a wrong edge and a missing cut-off.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

  localparam int NS_W = 30;
  localparam logic [31:0] PERIOD_MAX = 32'h3FFF_FFFF;
  localparam logic [31:0] PERIOD_FLOOR = 32'd6;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_HIGH = 2'd1,
    REG_CFG  = 2'd2
  } reg_sel_e;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;

  typedef struct packed {
    logic sync;
    logic action;
  } pin_cfg_t;

  function automatic logic period_ok(input logic [31:0] v);
    return (v > PERIOD_FLOOR) && (v <= PERIOD_MAX);
  endfunction

  function automatic logic [NS_W-1:0] ns_advance(input logic [NS_W-1:0] ns,
                                                 input int unsigned step,
                                                 input int unsigned wrap);
    logic [NS_W:0] sum;
    logic [NS_W:0] lim;
    sum = {1'b0, ns} + (NS_W+1)'(step);
    lim = (NS_W+1)'(wrap);
    if (sum >= lim) sum = sum - lim;
    return sum[NS_W-1:0];
  endfunction

  function automatic logic in_pulse(input logic [NS_W-1:0] ns,
                                    input logic [NS_W-1:0] delay,
                                    input logic [NS_W-1:0] width);
    logic [NS_W:0] stop;
    stop = {1'b0, delay} + {1'b0, width};
    return ({1'b0, ns} >= {1'b0, delay}) && ({1'b0, ns} < stop);
  endfunction

endpackage

// File: rtl/tpw_tod.sv
module tpw_tod #(
  parameter int unsigned NS_STEP = 4,
  parameter int unsigned NS_WRAP = 1_000_000_000,
  parameter int          SEC_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [tpw_pkg::NS_W-1:0] ns_q,
  output logic [tpw_pkg::NS_W-1:0] ns_nx,
  output logic [SEC_W-1:0]         sec_q,
  output logic                     sec_tick
);
  import tpw_pkg::*;

  always_comb begin
    ns_nx    = ns_advance(ns_q, NS_STEP, NS_WRAP);
    sec_tick = (ns_nx < ns_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      ns_q <= ns_nx;
      if (sec_tick) sec_q <= sec_q + 1'b1;
    end
  end

endmodule

// File: rtl/tpw_pin.sv
module tpw_pin #(
  parameter int unsigned NS_STEP    = 4,
  parameter int unsigned DEF_PERIOD = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_low,
  input  logic                     wr_high,
  input  logic                     wr_cfg,
  input  logic [31:0]              wr_data,
  input  logic                     sec_tick,
  input  logic [tpw_pkg::NS_W-1:0] ns_nx,
  output logic                     pin_q,
  output logic                     active,
  output logic                     sync_mode
);
  import tpw_pkg::*;

  localparam logic [NS_W-1:0] STEP_NS = NS_W'(NS_STEP);
  localparam logic [NS_W-1:0] DEF_NS  = NS_W'(DEF_PERIOD);

  logic [NS_W-1:0] low_q, high_q;
  logic [NS_W-1:0] shd_low_q, shd_high_q;
  logic [NS_W-1:0] shd_low_nx, shd_high_nx;
  logic [NS_W-1:0] rem_q;
  pin_cfg_t        cfg_q, cfg_wr;
  phase_e          phase_q;
  logic            armed_q, armed_nx;
  logic            phase_end;
  logic            sync_win;

  assign cfg_wr    = pin_cfg_t'(wr_data[1:0]);
  assign active    = cfg_q.action;
  assign sync_mode = cfg_q.sync;
  assign phase_end = (rem_q <= STEP_NS);

  // Durations used by the seconds-locked window: captured on each seconds increment.
  always_comb begin
    shd_low_nx  = sec_tick ? low_q  : shd_low_q;
    shd_high_nx = sec_tick ? high_q : shd_high_q;
    armed_nx    = armed_q | sec_tick;
    sync_win    = armed_nx && in_pulse(ns_nx, shd_low_nx, shd_high_nx);
  end

  // Duration registers: out-of-range writes are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= DEF_NS;
      high_q <= DEF_NS;
    end else begin
      if (wr_low  && period_ok(wr_data)) low_q  <= wr_data[NS_W-1:0];
      if (wr_high && period_ok(wr_data)) high_q <= wr_data[NS_W-1:0];
    end
  end

  // Generator state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      pin_q      <= 1'b0;
      phase_q    <= PH_HIGH;
      rem_q      <= '0;
      armed_q    <= 1'b0;
      shd_low_q  <= DEF_NS;
      shd_high_q <= DEF_NS;
    end else if (wr_cfg) begin
      cfg_q   <= cfg_wr;
      armed_q <= 1'b0;
      phase_q <= PH_HIGH;
      rem_q   <= high_q;
      pin_q   <= cfg_wr.action && !cfg_wr.sync;
    end else if (cfg_q.action) begin
      if (cfg_q.sync) begin
        armed_q    <= armed_nx;
        shd_low_q  <= shd_low_nx;
        shd_high_q <= shd_high_nx;
        pin_q      <= sync_win;
      end else if (phase_end) begin
        phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
        rem_q   <= (phase_q == PH_HIGH) ? low_q : high_q;
        pin_q   <= (phase_q == PH_LOW);
      end else begin
        rem_q <= rem_q - STEP_NS;
      end
    end else begin
      pin_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tod_pin_wavegen.sv
module tod_pin_wavegen #(
  parameter int          NPINS      = 4,
  parameter int unsigned NS_STEP    = 4,
  parameter int unsigned NS_WRAP    = 1_000_000_000,
  parameter int          SEC_W      = 32,
  parameter int unsigned DEF_PERIOD = 1000,
  localparam int         PIN_AW     = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int         ADDR_W     = PIN_AW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  output logic [NPINS-1:0]         pin_out,
  output logic [SEC_W-1:0]         tod_sec,
  output logic [tpw_pkg::NS_W-1:0] tod_ns
);
  import tpw_pkg::*;

  logic [NS_W-1:0]  tod_ns_nx;
  logic             sec_tick;
  logic [NPINS-1:0] pin_active;
  logic [NPINS-1:0] pin_sync;
  reg_sel_e         wr_reg;

  assign wr_reg = reg_sel_e'(wr_addr[1:0]);

  tpw_tod #(
    .NS_STEP(NS_STEP),
    .NS_WRAP(NS_WRAP),
    .SEC_W  (SEC_W)
  ) u_tod (
    .clk     (clk),
    .rst_n   (rst_n),
    .ns_q    (tod_ns),
    .ns_nx   (tod_ns_nx),
    .sec_q   (tod_sec),
    .sec_tick(sec_tick)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel;
    assign sel = wr_en && (wr_addr[ADDR_W-1:2] == PIN_AW'(i));

    tpw_pin #(
      .NS_STEP   (NS_STEP),
      .DEF_PERIOD(DEF_PERIOD)
    ) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_low   (sel && (wr_reg == REG_LOW)),
      .wr_high  (sel && (wr_reg == REG_HIGH)),
      .wr_cfg   (sel && (wr_reg == REG_CFG)),
      .wr_data  (wr_data),
      .sec_tick (sec_tick),
      .ns_nx    (tod_ns_nx),
      .pin_q    (pin_out[i]),
      .active   (pin_active[i]),
      .sync_mode(pin_sync[i])
    );
  end

endmodule

// File: rtl/tod_pin_wavegen_checker.sv
module tod_pin_wavegen_checker #(
  parameter int          NPINS   = 4,
  parameter int unsigned NS_STEP = 4,
  parameter int unsigned NS_WRAP = 1_000_000_000,
  parameter int          SEC_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [tpw_pkg::NS_W-1:0] tod_ns,
  input logic [SEC_W-1:0]         tod_sec,
  input logic                     sec_tick,
  input logic [NPINS-1:0]         pin_out,
  input logic [NPINS-1:0]         pin_active,
  input logic [NPINS-1:0]         pin_sync
);
  import tpw_pkg::*;

  localparam logic [NS_W-1:0] STEP_NS = NS_W'(NS_STEP);
  localparam logic [NS_W-1:0] WRAP_NS = NS_W'(NS_WRAP);
  localparam logic [NS_W-1:0] QUIET   = NS_W'(PERIOD_FLOOR) + 1'b1;

  // R2: nanosecond count stays below the wrap value
  a_r2_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < WRAP_NS);

  // R2: without a wrap the count moves by exactly one step, seconds held
  a_r2_ns_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> (tod_ns == $past(tod_ns) + STEP_NS) && $stable(tod_sec));

  // R2: a wrap increments the seconds and lands below one step
  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (tod_sec == $past(tod_sec) + 1'b1) && (tod_ns < STEP_NS));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    // R3: an idle pin drives low
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_active[i] |-> !pin_out[i]);

    // R9: the smallest legal delay keeps a locked pin low just after the seconds increment
    a_r9_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_active[i] && pin_sync[i] && (tod_ns < QUIET)) |-> !pin_out[i]);
  end

endmodule

bind tod_pin_wavegen tod_pin_wavegen_checker #(
  .NPINS  (NPINS),
  .NS_STEP(NS_STEP),
  .NS_WRAP(NS_WRAP),
  .SEC_W  (SEC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tod_ns    (tod_ns),
  .tod_sec   (tod_sec),
  .sec_tick  (sec_tick),
  .pin_out   (pin_out),
  .pin_active(pin_active),
  .pin_sync  (pin_sync)
);

// File: tb/tod_pin_wavegen_bench.sv
module tod_pin_wavegen_bench;
  localparam int NPINS = 4;
  localparam int STEP  = 4;
  localparam int WRAP  = 2000;
  localparam int NVEC  = 5;
  // pin, low ns, high ns
  localparam int VEC [NVEC][3] = '{
    '{0, 40, 20}, '{1, 7, 9}, '{2, 100, 8}, '{3, 12, 30}, '{0, 8, 8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NPINS-1:0] pin_out;
  logic [31:0] tod_sec;
  logic [29:0] tod_ns;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tod_pin_wavegen #(.NPINS(NPINS), .NS_STEP(STEP), .NS_WRAP(WRAP)) u_tod_pin_wavegen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_out(pin_out), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cyc(input int ns);
    return (ns + STEP - 1) / STEP;
  endfunction

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input int pin, input int rsel, input logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = {2'(pin), 2'(rsel)};
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_len(input int p, input logic lvl, output int n);
    n = 0;
    while (pin_out[p] == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sync_mon(input int p, input int d, input int w, input int ncyc,
                          output int mism, output int highs);
    logic armed = 1'b0;
    logic exp;
    int s0 = int'(tod_sec);
    mism = 0;
    highs = 0;
    for (int n = 0; n < ncyc; n++) begin
      if (int'(tod_sec) != s0) armed = 1'b1;
      exp = armed && (int'(tod_ns) >= d) && (int'(tod_ns) < d + w);
      if (pin_out[p] !== exp) mism++;
      if (pin_out[p]) highs++;
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int a, b, s, nh, nl, mism, highs;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pins", pin_out, 0);
    chk("R1 ns", tod_ns, 0);
    chk("R1 sec", tod_sec, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 step and wrap
    a = int'(tod_ns);
    @(negedge clk);
    b = int'(tod_ns);
    chk("R2 step", b, (a + STEP) % WRAP);
    for (int k = 0; k < 1000 && int'(tod_ns) != WRAP - STEP; k++) @(negedge clk);
    s = int'(tod_sec);
    @(negedge clk);
    chk("R2 wrap ns", tod_ns, 0);
    chk("R2 wrap sec", tod_sec, s + 1);

    // R4 free-running timing from the vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][0], 0, VEC[k][1]);
      wr(VEC[k][0], 1, VEC[k][2]);
      wr(VEC[k][0], 2, 1);
      chk("R4 starts high", pin_out[VEC[k][0]], 1);
      run_len(VEC[k][0], 1'b1, nh);
      chk("R4 high cycles", nh, cyc(VEC[k][2]));
      run_len(VEC[k][0], 1'b0, nl);
      chk("R4 low cycles", nl, cyc(VEC[k][1]));
    end
    for (int p = 0; p < NPINS; p++) wr(p, 2, 0);

    // R3 register 3 is not a register: pin 0 must stay idle
    wr(0, 3, 1);
    nh = 0;
    for (int k = 0; k < 20; k++) begin
      if (pin_out[0]) nh++;
      @(negedge clk);
    end
    chk("R3 reg3 ignored", nh, 0);

    // R6 out-of-range durations rejected
    wr(1, 0, 40);
    wr(1, 1, 40);
    wr(1, 1, 6);
    wr(1, 1, 32'h4000_0000);
    wr(1, 1, 0);
    wr(1, 2, 1);
    run_len(1, 1'b1, nh);
    chk("R6 high kept", nh, 10);

    // R5 staggered starts stay staggered
    wr(0, 0, 20);
    wr(0, 1, 20);
    wr(1, 0, 20);
    wr(1, 1, 20);
    wr(0, 2, 1);
    wr(1, 2, 1);
    repeat (4) @(negedge clk);
    chk("R5 pin0 offset", pin_out[0], 0);
    chk("R5 pin1 offset", pin_out[1], 1);

    // R7 update mid-phase
    wr(2, 0, 40);
    wr(2, 1, 40);
    wr(2, 2, 1);
    wr(2, 1, 80);
    run_len(2, 1'b1, nh);
    chk("R7 current high kept", nh, 9);
    run_len(2, 1'b0, nl);
    chk("R7 low", nl, 10);
    run_len(2, 1'b1, nh);
    chk("R7 new high", nh, 20);

    // R8 stop and resume
    wr(2, 2, 0);
    chk("R8 stopped", pin_out[2], 0);
    nh = 0;
    for (int k = 0; k < 30; k++) begin
      if (pin_out[2]) nh++;
      @(negedge clk);
    end
    chk("R8 stays low", nh, 0);
    wr(2, 2, 1);
    run_len(2, 1'b1, nh);
    chk("R8 resume high", nh, 20);
    run_len(2, 1'b0, nl);
    chk("R8 resume low", nl, 10);

    // R9 seconds-locked pulse
    wr(3, 0, 100);
    wr(3, 1, 200);
    wr(3, 2, 3);
    sync_mon(3, 100, 200, 3 * WRAP / STEP, mism, highs);
    chk("R9 window mismatches", mism, 0);
    chk("R9 pulses seen", highs >= 2 * cyc(200), 1);

    // R10 pulse cut at the seconds increment
    wr(3, 0, 1900);
    wr(3, 1, 400);
    wr(3, 2, 3);
    sync_mon(3, 1900, 400, 3 * WRAP / STEP, mism, highs);
    chk("R10 window mismatches", mism, 0);
    chk("R10 clipped pulses seen", highs >= 2 * cyc(WRAP - 1900), 1);

    summary();
    $finish;
  end

endmodule